// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-mapped watchdog. A 16-bit down-counter is advanced by a tick. The tick comes from two divider stages in series: a programmable prescaler with a factor of 1 to 256, then a fixed divider of 16, 32, 64 or 128 picked by a two-bit field. When the counter expires, the block reloads it from a reload register. It can also signal the expiry as a one-cycle interrupt pulse, a reset output held for a fixed number of cycles, or both.

Software programs the reload value and the control word. To keep the timer from expiring, it rewrites the live counter before the counter runs out. The register port is synchronous: a write takes effect at the clock edge where the write enable is high. Read data is a combinational decode of the address.

Top module: `presc_wdog`

## Requirements
- R1: After reset every register reads zero. The interrupt and reset outputs are low and the timer is stopped.
- R2: Registers are at byte offsets 0x0 (control), 0x4 (reload value) and 0x8 (live counter). Each one reads back what was written to it. Any other offset reads zero.
- R3: The control fields are: bit 5 runs the timer, bits 15:8 hold the prescale value P, and bits 4:3 hold the divider code S, where 0, 1, 2 and 3 give 16, 32, 64 and 128. While running, the block produces one tick every (P+1)*(16<<S) clock cycles. The first tick arrives that many edges after the edge that set bit 5.
- R4: A tick that finds the counter at zero is an expiry. An expiry reloads the counter from the reload register in the same edge. Any other tick decrements the counter. A count of N therefore expires on tick N+1.
- R5: The interrupt output is a pulse exactly one cycle wide. It rises at the expiry edge, and only when control bit 2 is set.
- R6: When control bit 0 is set, an expiry raises the reset output at the expiry edge. The reset output then stays high for exactly 128 cycles. When bit 0 is clear, the reset output stays low.
- R7: A write to the counter offset loads the counter at that edge, and takes priority over a tick in the same edge. Regular rewrites keep the timer from ever expiring.
- R8: A write to the reload register does not alter the live counter.
- R9: While bit 5 is clear, the counter holds its value. Both divider stages restart from zero, so the block gives a full tick period after it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr |
| irq | output | 1 | One-cycle expiry interrupt |
| sys_rst | output | 1 | Expiry reset, held 128 cycles |

## Verification
The hardest state to reach from the ports is a stop partway through a tick period. The two divider stages then hold partial counts that the ports never show. The stimulus enables the timer, stops it at a cycle that falls between ticks, and reads back the frozen counter. It then re-enables the timer and times the next interrupt. Only a full tick period per remaining count matches the expected value, so a stage that kept its partial count would make the interrupt arrive early.

// File: rtl/presc_wdog.sv
module presc_wdog #(
  parameter int AW       = 4,
  parameter int RST_HOLD = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  output logic          irq,
  output logic          sys_rst
);
  localparam logic [AW-1:0] A_CTRL = AW'(4'h0);
  localparam logic [AW-1:0] A_DATA = AW'(4'h4);
  localparam logic [AW-1:0] A_CNT  = AW'(4'h8);
  localparam int HW = $clog2(RST_HOLD + 1);

  logic [15:0]   ctrl_q, data_q, cnt_q;
  logic [7:0]    pcnt_q;
  logic [6:0]    dcnt_q;
  logic [HW-1:0] hold_q;

  wire       run     = ctrl_q[5];
  wire       rst_en  = ctrl_q[0];
  wire       irq_en  = ctrl_q[2];
  wire [1:0] div_sel = ctrl_q[4:3];
  wire [7:0] presc   = ctrl_q[15:8];
  wire [6:0] dmax    = {div_sel == 2'd3, div_sel >= 2'd2, div_sel != 2'd0, 4'hF};

  wire s1_tick = run && (pcnt_q == presc);
  wire tick    = s1_tick && (dcnt_q == dmax);
  wire expire  = tick && (cnt_q == '0);

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wr_data_r = wr_en && (addr == A_DATA);
  wire wr_cnt  = wr_en && (addr == A_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data;
      if (wr_data_r) data_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      pcnt_q <= s1_tick ? 8'd0 : pcnt_q + 8'd1;
      if (s1_tick) dcnt_q <= (dcnt_q == dmax) ? 7'd0 : dcnt_q + 7'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (expire) cnt_q <= data_q;
    else if (tick)   cnt_q <= cnt_q - 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      hold_q <= '0;
    end else begin
      irq <= expire && irq_en;
      if (expire && rst_en)    hold_q <= HW'(RST_HOLD);
      else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
    end
  end

  assign sys_rst = (hold_q != '0);

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = ctrl_q;
      A_DATA:  rd_data = data_q;
      A_CNT:   rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/presc_wdog_chk.sv
module presc_wdog_chk #(
  parameter int AW       = 4,
  parameter int RST_HOLD = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [15:0]   wr_data,
  input logic [15:0]   ctrl_q,
  input logic [15:0]   cnt_q,
  input logic          irq,
  input logic          sys_rst
);
  logic [15:0] hi_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       hi_q <= '0;
    else if (sys_rst) hi_q <= hi_q + 16'd1;
    else              hi_q <= '0;
  end

  wire cnt_wr = wr_en && (addr == AW'(4'h8));

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_q[2]));
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_rst_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(ctrl_q[0]));
  assert_rst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_q >= 16'(RST_HOLD)));
  assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wr_data)));
  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[5] && !cnt_wr) |=> $stable(cnt_q));
endmodule

bind presc_wdog presc_wdog_chk #(.AW(AW), .RST_HOLD(RST_HOLD)) u_chk (.*);

// File: tb/presc_wdog_bench.sv
module presc_wdog_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = 0;
  logic        wr_en = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic        irq, sys_rst;
  int n_chk = 0, n_fail = 0;

  presc_wdog u_presc_wdog (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst));

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output int v);
    addr = a; #0.5; v = rd_data;
  endtask

  task automatic wait_evt(bit use_rst, output int k);
    k = 0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk); k++;
      if (use_rst ? sys_rst : irq) return;
    end
    k = -1;
  endtask

  function automatic logic [15:0] cw(int p, int s, bit run, bit ie, bit re);
    return 16'((p << 8) | (s << 3) | (int'(run) << 5) | (int'(ie) << 2) | int'(re));
  endfunction

  task automatic t_reset;
    int v;
    rd(4'h0, v); chk("R1 ctrl", v, 0);
    rd(4'h4, v); chk("R1 data", v, 0);
    rd(4'h8, v); chk("R1 count", v, 0);
    chk("R1 irq", irq, 0); chk("R1 sys_rst", sys_rst, 0);
  endtask

  task automatic t_regs;
    int v;
    wr(4'h4, 16'h1234); rd(4'h4, v); chk("R2 data readback", v, 16'h1234);
    wr(4'h8, 16'h00AB); rd(4'h8, v); chk("R2 count readback", v, 16'h00AB);
    wr(4'h0, 16'hA318); rd(4'h0, v); chk("R2 ctrl readback", v, 16'hA318);
    rd(4'hC, v); chk("R2 unmapped", v, 0);
    wr(4'h0, 0);
  endtask

  task automatic t_period(int p, int s, int n);
    int k;
    wr(4'h0, 0); wr(4'h8, 16'(n));
    wr(4'h0, cw(p, s, 1, 1, 0));
    wait_evt(0, k);
    chk($sformatf("R3 R4 period p=%0d s=%0d n=%0d", p, s, n), k, (n + 1) * (p + 1) * (16 << s));
    chk("R6 no reset when disabled", sys_rst, 0);
    @(negedge clk); chk("R5 single pulse", irq, 0);
    wr(4'h0, 0);
  endtask

  task automatic t_reload;
    int k, v;
    wr(4'h4, 4); wr(4'h8, 0);
    wr(4'h0, cw(0, 0, 1, 1, 0));
    wait_evt(0, k); chk("R4 first expiry", k, 16);
    rd(4'h8, v); chk("R4 reload value", v, 4);
    wait_evt(0, k); chk("R4 reload period", k, 80);
    wr(4'h0, 0);
  endtask

  task automatic t_data_write;
    int v;
    wr(4'h8, 5); wr(4'h4, 9);
    rd(4'h8, v); chk("R8 count unchanged", v, 5);
    rd(4'h4, v); chk("R8 data set", v, 9);
  endtask

  task automatic t_keepalive;
    int seen = 0;
    wr(4'h8, 2); wr(4'h0, cw(0, 0, 1, 1, 1));
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (irq || sys_rst) seen++; end
      wr(4'h8, 2);
    end
    chk("R7 keepalive prevents expiry", seen, 0);
    wr(4'h0, 0);
  endtask

  task automatic t_stop;
    int v, v2, k;
    wr(4'h8, 3); wr(4'h0, cw(0, 0, 1, 1, 0));
    repeat (40) @(negedge clk);
    wr(4'h0, cw(0, 0, 0, 1, 0));
    rd(4'h8, v);
    repeat (100) @(negedge clk);
    rd(4'h8, v2); chk("R9 count holds", v2, v);
    chk("R9 count advanced before stop", v, 1);
    wr(4'h0, cw(0, 0, 1, 1, 0));
    wait_evt(0, k); chk("R9 full period after restart", k, (v + 1) * 16);
    wr(4'h0, 0);
  endtask

  task automatic t_rst_out(bit ie);
    int k, hi = 1;
    wr(4'h4, 16'hFFFF); wr(4'h8, 1);
    wr(4'h0, cw(0, 0, 1, ie, 1));
    wait_evt(1, k);
    chk("R6 reset rise time", k, 32);
    chk("R5 R6 irq follows enable", irq, ie);
    while (hi < 1000) begin @(negedge clk); if (!sys_rst) break; hi++; end
    chk("R6 reset width", hi, 128);
    wr(4'h0, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_period(0, 0, 2);
    t_period(2, 1, 1);
    t_period(0, 2, 0);
    t_period(1, 3, 0);
    t_reload;
    t_data_write;
    t_keepalive;
    t_stop;
    t_rst_out(0);
    t_rst_out(1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule